// File: doc/BRIEF.md
# Character LCD Power-Up Sequencer

This block brings an 8-bit parallel character display controller out of reset and then acts as the only path to it. After reset it stays silent for a long power-up interval. It then sends nine command bytes, all with register select low. The first byte selects the extended instruction table. The next four set bias, booster/power, follower gain and contrast. A sixth byte returns to the normal table, and the last three turn the display on with no cursor, clear it and select forward increment. A fixed settle interval follows each command. After the last one the block reads the status byte until the busy flag is clear, and only then raises `init_done`.

Requests leave the block through a single request channel toward a parallel bus engine. Each request is either a byte write or a status read, and it carries the register-select level. Read results return on a one-cycle response strobe. A user port (valid/ready) then accepts command or character bytes. Each accepted byte is forwarded unchanged and followed by busy-flag polling, so the user port reopens only when the display is idle.

States: `ST_BOOT` (load the power-up count) → `ST_POWERUP` (count expires) → `ST_CMD_SEND` (request accepted) → `ST_CMD_SETTLE`. From there, when the count expires, the block goes back to `ST_CMD_SEND` for the next index, or to `ST_POLL_SEND` after the last one. `ST_POLL_SEND` (read accepted) → `ST_POLL_WAIT`. On a response the block goes to `ST_POLL_SEND` if busy, or `ST_IDLE` if clear. `ST_IDLE` (user byte captured) → `ST_USER_SEND` (request accepted) → `ST_POLL_SEND`.

Top module: `lcd_init_seq`

## Requirements
- R1: While reset is held, `req_valid`, `init_done` and `user_ready` are 0 and `seq_idx` is 0.
- R2: No request is presented in the first `POWERUP_CYCLES` cycles after reset is released.
- R3: The first nine requests are writes with `req_rs` = 0, carrying in order 0x39, 0x15, 0x55, 0x6E, 0x72, 0x38, 0x0C, 0x01, 0x06.
- R4: At least `CMD_WAIT_CYCLES` cycles separate the acceptance of an initialization command from the next request.
- R5: While an initialization command is presented, `seq_idx` equals its position in the sequence (0 for the first byte, 8 for the last).
- R6: After the ninth command, the block issues status reads (`req_write` = 0, `req_rs` = 0) until a response has bit 7 (busy) equal to 0. `init_done` rises only after such a response and then stays 1.
- R7: `user_ready` stays 0 until `init_done` is 1. A byte accepted on the user port is forwarded as a write with the same `user_rs` level (0 = command, 1 = character) and the same data.
- R8: After each forwarded user write, `user_ready` stays 0 and no further write is issued until a status read returns busy = 0.
- R9: `addr_cnt` shows bits 6:0 of the most recent status response.
- R10: While `req_valid` is 1 and `req_ready` is 0, `req_valid`, `req_write`, `req_rs` and `req_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | output | 1 | Request to the bus engine is presented |
| req_write | output | 1 | 1 = byte write, 0 = status read |
| req_rs | output | 1 | Register select: 0 = command/status, 1 = character data |
| req_data | output | 8 | Byte to write |
| req_ready | input | 1 | Bus engine accepts the request this cycle |
| rsp_valid | input | 1 | Status byte returned this cycle |
| rsp_data | input | 8 | Status byte: bit 7 busy, bits 6:0 address counter |
| init_done | output | 1 | Power-up sequence finished and display idle |
| seq_idx | output | 4 | Index of the current initialization command |
| addr_cnt | output | 7 | Address counter from the latest status read |
| user_valid | input | 1 | User byte offered |
| user_rs | input | 1 | Register select of the user byte |
| user_data | input | 8 | User byte |
| user_ready | output | 1 | User byte accepted this cycle when valid |

## Verification
A wrong state register or index shows up at the request channel at the next command presentation. That may be a byte out of order, a `seq_idx` mismatch, or a gap shorter than the settle count. A broken poll loop shows up within one response. Either `init_done` or `user_ready` rises while the engine still reports busy, or a user write appears with no clear status before it. A corrupted capture of the user byte is visible on the very next write request, and a stale address counter is visible as soon as the port reopens.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;

    localparam int unsigned CMD_COUNT = 9;
    localparam int unsigned SEQ_W     = $clog2(CMD_COUNT);
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned BUSY_BIT  = BYTE_W - 1;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_POWERUP,
        ST_CMD_SEND,
        ST_CMD_SETTLE,
        ST_POLL_SEND,
        ST_POLL_WAIT,
        ST_IDLE,
        ST_USER_SEND
    } seq_state_t;

    // Power-up command bytes; the order is the behaviour.
    function automatic logic [BYTE_W-1:0] init_cmd(input logic [SEQ_W-1:0] k);
        logic [BYTE_W-1:0] b;
        case (k)
            4'd0:    b = 8'h39;  // 8-bit bus, two lines, extended table
            4'd1:    b = 8'h15;  // bias
            4'd2:    b = 8'h55;  // booster on, power
            4'd3:    b = 8'h6E;  // follower gain
            4'd4:    b = 8'h72;  // contrast low bits
            4'd5:    b = 8'h38;  // back to normal table
            4'd6:    b = 8'h0C;  // display on, cursor off, no blink
            4'd7:    b = 8'h01;  // clear
            4'd8:    b = 8'h06;  // forward increment
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lcd_wait_timer.sv
module lcd_wait_timer #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             expired
);

    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    AST_TMR_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && expired) |=> expired); // R4

endmodule

// File: rtl/lcd_cmd_rom.sv
module lcd_cmd_rom
    import lcd_init_pkg::*;
(
    input  logic [SEQ_W-1:0]  idx,
    output logic [BYTE_W-1:0] cmd_byte
);

    assign cmd_byte = init_cmd(idx);

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
    import lcd_init_pkg::*;
#(
    parameter int unsigned POWERUP_CYCLES  = 3_750_000,
    parameter int unsigned CMD_WAIT_CYCLES = 3_750
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              req_valid,
    output logic              req_write,
    output logic              req_rs,
    output logic [BYTE_W-1:0] req_data,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic [BYTE_W-1:0] rsp_data,
    output logic              init_done,
    output logic [SEQ_W-1:0]  seq_idx,
    output logic [BYTE_W-2:0] addr_cnt,
    input  logic              user_valid,
    input  logic              user_rs,
    input  logic [BYTE_W-1:0] user_data,
    output logic              user_ready
);

    localparam int unsigned MAX_WAIT = (POWERUP_CYCLES > CMD_WAIT_CYCLES) ?
                                       POWERUP_CYCLES : CMD_WAIT_CYCLES;
    localparam int unsigned TMR_W    = ($clog2(MAX_WAIT + 1) < 1) ? 1 : $clog2(MAX_WAIT + 1);
    localparam logic [SEQ_W-1:0] LAST_IDX = SEQ_W'(CMD_COUNT - 1);

    seq_state_t        state_q, state_d;
    logic [SEQ_W-1:0]  idx_q;
    logic              done_q;
    logic [BYTE_W-2:0] addr_q;
    logic              ub_rs_q;
    logic [BYTE_W-1:0] ub_data_q;

    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic [BYTE_W-1:0] rom_byte;
    logic              stat_busy;

    assign stat_busy = rsp_data[BUSY_BIT];

    lcd_wait_timer #(.WIDTH(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    lcd_cmd_rom u_rom (
        .idx      (idx_q),
        .cmd_byte (rom_byte)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:       state_d = ST_POWERUP;
            ST_POWERUP:    if (tmr_expired) state_d = ST_CMD_SEND;
            ST_CMD_SEND:   if (req_ready) state_d = ST_CMD_SETTLE;
            ST_CMD_SETTLE: if (tmr_expired)
                               state_d = (idx_q == LAST_IDX) ? ST_POLL_SEND : ST_CMD_SEND;
            ST_POLL_SEND:  if (req_ready) state_d = ST_POLL_WAIT;
            ST_POLL_WAIT:  if (rsp_valid)
                               state_d = stat_busy ? ST_POLL_SEND : ST_IDLE;
            ST_IDLE:       if (user_valid) state_d = ST_USER_SEND;
            ST_USER_SEND:  if (req_ready) state_d = ST_POLL_SEND;
        endcase
    end

    // Data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q     <= '0;
            done_q    <= 1'b0;
            addr_q    <= '0;
            ub_rs_q   <= 1'b0;
            ub_data_q <= '0;
        end else begin
            if (state_q == ST_CMD_SETTLE && tmr_expired && idx_q != LAST_IDX)
                idx_q <= idx_q + 1'b1;
            if (state_q == ST_POLL_WAIT && rsp_valid) begin
                addr_q <= rsp_data[BYTE_W-2:0];
                if (!stat_busy) done_q <= 1'b1;
            end
            if (state_q == ST_IDLE && user_valid) begin
                ub_rs_q   <= user_rs;
                ub_data_q <= user_data;
            end
        end
    end

    // Outputs
    always_comb begin
        req_valid  = 1'b0;
        req_write  = 1'b1;
        req_rs     = 1'b0;
        req_data   = '0;
        user_ready = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = TMR_W'(CMD_WAIT_CYCLES);
        unique case (state_q)
            ST_BOOT: begin
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(POWERUP_CYCLES);
            end
            ST_POWERUP, ST_CMD_SETTLE, ST_POLL_WAIT: ;
            ST_CMD_SEND: begin
                req_valid = 1'b1;
                req_data  = rom_byte;
                tmr_load  = req_ready;
            end
            ST_POLL_SEND: begin
                req_valid = 1'b1;
                req_write = 1'b0;
            end
            ST_IDLE: user_ready = 1'b1;
            ST_USER_SEND: begin
                req_valid = 1'b1;
                req_rs    = ub_rs_q;
                req_data  = ub_data_q;
            end
        endcase
    end

    assign init_done = done_q;
    assign seq_idx   = idx_q;
    assign addr_cnt  = addr_q;

    AST_CMD_RS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !init_done) |-> !req_rs); // R3
    AST_STATUS_RS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |-> !req_rs); // R6
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done); // R6
    AST_DONE_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(rsp_valid && !rsp_data[BUSY_BIT])); // R6
    AST_READY_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        user_ready |-> init_done); // R7
    AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(user_ready && req_valid)); // R8
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_idx <= LAST_IDX); // R5
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_write)
                                       && $stable(req_rs) && $stable(req_data))); // R10

endmodule

// File: tb/sim_lcd_init_seq.sv
module sim_lcd_init_seq;
    import lcd_init_pkg::*;

    localparam int unsigned P_UP   = 200;
    localparam int unsigned P_WAIT = 20;
    localparam int          N_USER = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid, req_write, req_rs, req_ready = 1'b0;
    logic [7:0] req_data;
    logic       rsp_valid = 1'b0;
    logic [7:0] rsp_data = 8'h00;
    logic       init_done;
    logic [3:0] seq_idx;
    logic [6:0] addr_cnt;
    logic       user_valid = 1'b0, user_rs = 1'b0;
    logic [7:0] user_data = 8'h00;
    logic       user_ready;

    always #4 clk = ~clk;

    lcd_init_seq #(.POWERUP_CYCLES(P_UP), .CMD_WAIT_CYCLES(P_WAIT)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_rs(req_rs),
        .req_data(req_data), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .init_done(init_done), .seq_idx(seq_idx), .addr_cnt(addr_cnt),
        .user_valid(user_valid), .user_rs(user_rs), .user_data(user_data),
        .user_ready(user_ready)
    );

    int n_tests = 0, n_fail = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_cmd(input int k);
        logic [7:0] tbl [9] = '{8'h39, 8'h15, 8'h55, 8'h6E, 8'h72, 8'h38, 8'h0C, 8'h01, 8'h06};
        return tbl[k];
    endfunction

    // Bus engine model state
    bit         seen = 0, clear_flag = 0, init_clear = 0;
    bit         mon_early = 0, mon_pre = 0, mon_busy = 0;
    int         start_cyc = 0, delay = 0, last_hs = 0, rel_cyc = 0;
    int         cmds = 0, rsp_cnt = 0, busy_left = 0;
    logic [7:0] st_data;
    logic       st_rs, st_wr;
    logic [6:0] last_addr = 7'h00;
    logic       u_rs  [N_USER];
    logic [7:0] u_dat [N_USER];
    int         u_in = 0, u_out = 0;

    task automatic on_hs();
        chk(st_data == req_data && st_rs == req_rs && st_wr == req_write,
            "R10 request held while stalled", {req_write, req_rs, req_data}, {st_wr, st_rs, st_data});
        if (cmds < 9) begin
            chk(req_write == 1'b1, "R3 init request is a write", req_write, 1);
            chk(req_rs == 1'b0, "R3 init command rs low", req_rs, 0);
            chk(req_data == exp_cmd(cmds), "R3 command byte order", req_data, exp_cmd(cmds));
            chk(seq_idx == cmds[3:0], "R5 sequence index", seq_idx, cmds);
            if (cmds == 0)
                chk(start_cyc - rel_cyc >= int'(P_UP), "R2 power-up wait", start_cyc - rel_cyc, P_UP);
            else
                chk(start_cyc - last_hs >= int'(P_WAIT), "R4 settle gap", start_cyc - last_hs, P_WAIT);
            cmds++;
            if (cmds == 9) busy_left = 2;
        end else if (!req_write) begin
            chk(req_rs == 1'b0, "R6 status read rs low", req_rs, 0);
            rsp_cnt = 1 + int'($urandom % 3);
        end else begin
            chk(clear_flag, "R8 write only after clear status", clear_flag, 1);
            chk(u_out < u_in, "R7 write has a user byte", u_out, u_in);
            if (u_out < u_in) begin
                chk(req_rs == u_rs[u_out], "R7 forwarded rs", req_rs, u_rs[u_out]);
                chk(req_data == u_dat[u_out], "R7 forwarded data", req_data, u_dat[u_out]);
            end
            u_out++;
            clear_flag = 0;
            busy_left = int'($urandom % 4);
        end
        last_hs = cyc;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (init_done && !init_clear)     mon_early = 1;
            if (user_ready && !init_done)     mon_pre = 1;
            if (user_ready && !clear_flag)    mon_busy = 1;
            if (rsp_valid) rsp_valid = 1'b0;
            if (rsp_cnt > 0) begin
                rsp_cnt--;
                if (rsp_cnt == 0) begin
                    logic b;
                    b = (busy_left > 0);
                    if (b) busy_left--;
                    last_addr = 7'($urandom);
                    rsp_data  = {b, last_addr};
                    rsp_valid = 1'b1;
                    if (!b) begin
                        clear_flag = 1;
                        init_clear = 1;
                    end
                end
            end
            if (req_ready) begin
                req_ready = 1'b0;
                seen = 0;
            end else if (req_valid) begin
                if (!seen) begin
                    seen = 1;
                    start_cyc = cyc;
                    st_data = req_data;
                    st_rs = req_rs;
                    st_wr = req_write;
                    delay = int'($urandom % 4);
                end
                if (delay == 0) begin
                    req_ready = 1'b1;
                    on_hs();
                end else begin
                    delay--;
                end
            end
        end
    end

    task automatic wait_ready();
        do @(negedge clk); while (!user_ready);
    endtask

    task automatic send_user(input logic rs, input logic [7:0] d);
        wait_ready();
        chk(init_done == 1'b1, "R7 port open only after init", init_done, 1);
        chk(addr_cnt == last_addr, "R9 address counter", addr_cnt, last_addr);
        u_rs[u_in]  = rs;
        u_dat[u_in] = d;
        u_in++;
        user_rs = rs;
        user_data = d;
        user_valid = 1'b1;
        @(negedge clk);
        user_valid = 1'b0;
        chk(user_ready == 1'b0, "R8 port closes after accept", user_ready, 0);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R1 watchdog expired actual=%0d expected=done", cyc);
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(req_valid == 1'b0, "R1 reset req_valid", req_valid, 0);
        chk(init_done == 1'b0, "R1 reset init_done", init_done, 0);
        chk(user_ready == 1'b0, "R1 reset user_ready", user_ready, 0);
        chk(seq_idx == 4'd0, "R1 reset seq_idx", seq_idx, 0);
        rst_n = 1'b1;
        rel_cyc = cyc;
        // directed corner bytes
        send_user(1'b0, 8'h80);
        send_user(1'b1, 8'h41);
        send_user(1'b1, 8'h00);
        send_user(1'b1, 8'hFF);
        send_user(1'b0, 8'h01);
        for (int i = 5; i < N_USER; i++)
            send_user(1'($urandom), 8'($urandom));
        wait_ready();
        chk(addr_cnt == last_addr, "R9 final address counter", addr_cnt, last_addr);
        chk(cmds == 9, "R3 command count", cmds, 9);
        chk(u_out == u_in, "R7 all user bytes forwarded", u_out, u_in);
        chk(!mon_early, "R6 done only after clear status", mon_early, 0);
        chk(!mon_pre, "R7 ready low during init", mon_pre, 0);
        chk(!mon_busy, "R8 ready low while busy", mon_busy, 0);
        chk(init_done == 1'b1, "R6 done stays high", init_done, 1);
        summary();
        $finish;
    end

endmodule